// File: doc/BRIEF.md
# Ten-Bit Compressed Operation Decoder

This block sits in the front end of a core that mixes 16-bit parcels into a 32-bit instruction stream. It takes the 10-bit operation field of one compressed parcel and expands it into a single flat micro-op record. Later stages can then issue the operation without knowing the compressed format. The record holds:

- a class and an operation code
- three register indices
- a zero-operand flag
- a write enable and a compare enable, plus the condition field that a compare updates
- a link flag and condition-check controls
- a byte offset for branches
- an illegal flag

The parcel also carries a continue bit. It is passed through so the fetch logic knows whether the next parcel is also compressed.

The decoder is combinational and is followed by one register stage. A parcel presented with `in_vld` high shows its record on the outputs one clock later, and the record then holds until the next valid parcel. The five most significant parcel bits carry the opcode that entered compressed mode, and the decoder does not look at them. Bit positions below use normal little-endian numbering of the 16-bit `in_pcl`.

Top module: `pd10_decode`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs are cleared: `out_vld`, `out_ill`, `out_wr`, `out_cmp`, `out_lnk`, `out_cond_en` and `out_stay` read 0 after that edge.
- R2: A parcel sampled with `in_vld` high appears on the outputs after exactly one rising edge, with `out_vld` high. At an edge where `in_vld` is low, `out_vld` goes low and the record holds its previous value.
- R3: `in_pcl[10:8]` selects the group, and the output codes are fixed:
  - Group 010 decodes as add/mul, 011 as sub/cmp, 100 as and/nand, 101 as or/nor.
  - In these groups `in_pcl[7:5]` is RB, `in_pcl[4:2]` is RA, and `in_pcl[1]`=1 picks the second operation of the pair.
  - Non-compare operations set `out_rd`=RA and `out_wr`=1.
  - Class codes: 1 branch, 2 memory, 3 integer, 4 logical, 5 float, 6 condition-register.
  - Operation codes: 1 jump, 2 jump-link-reg, 3 jump-target-reg, 4 load, 5 store, 6 add, 7 mul, 8 sub, 9 cmp, 10 and, 11 nand, 12 or, 13 nor, 14 fadd, 15 fabs, 16 fmul, 17 fsub, 18 fcmp, 19 cr-op.
- R4: For sub, cmp, nor, fsub and fcmp, RA=0 sets `out_a_zero`=1. This is the zero-operand form: neg, compare with zero, not, fneg and float compare with zero. Every other operation leaves `out_a_zero`=0.
- R5: In group 110, `in_pcl[1]`=1 decodes as fmul. With `in_pcl[1]`=0, RA=0 decodes as fabs and any other RA decodes as fadd. Group 111 decodes as fsub/fcmp.
- R6: Integer cmp sets `out_cmp`=1 and `out_crf`=0. Float compare sets `out_cmp`=1 and `out_crf`=1. Both compares leave `out_wr`=0.
- R7: Group 000 is a relative jump:
  - `in_pcl[7:2]` is a signed count of 2-byte units.
  - `out_offs` is that count sign-extended and multiplied by 2.
  - `out_lnk`=`in_pcl[1]`.
- R8: Group 001 with `in_pcl[7:6]`=00 is a jump via the link register, and with 01 a jump via the target register. For both:
  - `out_cond_sel`=`in_pcl[5:4]`
  - `out_cond_en`=`in_pcl[3]`
  - `out_cond_inv`=`in_pcl[2]`
  - `out_lnk`=`in_pcl[1]`
- R9: For the R8 jumps, the combination `in_pcl[3]`=0 with `in_pcl[2]`=1 (invert without a check) is unlisted. It sets `out_ill`=1 and clears `out_wr`, `out_cmp`, `out_lnk`, `out_cond_en`, `out_cond_inv` and `out_a_zero`.
- R10: Group 001 with `in_pcl[7:6]`=11 and `in_pcl[1]`=0 is a load:
  - `out_ra`=`in_pcl[5:4]` and `out_rb`=`out_rd`=`in_pcl[3:2]`, both zero-extended.
  - `out_wr`=1.
- R11: The same sub-group with `in_pcl[1]`=1 is a store:
  - `out_ra`=`in_pcl[5:4]`, `out_rb`=`in_pcl[3:2]` (the data register).
  - `out_wr`=0 and `out_offs`=0.
- R12: Group 001 with `in_pcl[7:6]`=10 reports class 6, code 19, with no enables set and `out_ill`=0.
- R13: `out_stay` is the registered `in_pcl[0]`. Bits `in_pcl[15:11]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Parcel valid |
| in_pcl | input | 16 | Compressed parcel |
| out_vld | output | 1 | Record valid |
| out_cls | output | 3 | Operation class |
| out_opc | output | 5 | Operation code |
| out_ra | output | 3 | Source A register index |
| out_rb | output | 3 | Source B / store data register index |
| out_rd | output | 3 | Destination register index |
| out_a_zero | output | 1 | Source A replaced by zero |
| out_wr | output | 1 | Destination register written |
| out_cmp | output | 1 | Compare result written to a condition field |
| out_crf | output | 3 | Condition field targeted by a compare |
| out_lnk | output | 1 | Save return address |
| out_cond_en | output | 1 | Jump tests a condition bit |
| out_cond_inv | output | 1 | Condition test inverted |
| out_cond_sel | output | 2 | Bit of condition field 0 tested |
| out_offs | output | 8 | Signed jump offset in bytes |
| out_ill | output | 1 | Unlisted encoding |
| out_stay | output | 1 | Next parcel is also compressed |

## Verification
The block holds no state except the output register, so a wrong internal decision shows up as a wrong field exactly one cycle after the parcel is accepted. It is never delayed or hidden behind later traffic.

- A mis-steered group select shows up as a wrong class or operation code.
- A wrong zero-operand comparison shows up as a mismatched `out_a_zero` or a wrong choice between fabs and fadd.
- A faulty hold path shows up as a record that changes on idle cycles after a valid parcel.

// File: rtl/pd10_pkg.sv
package pd10_pkg;

    localparam int PCL_W = 16;
    localparam int REG_W = 3;
    localparam int SREG_W = 2;
    localparam int CRF_W = 3;
    localparam int FLD_W = 6;
    localparam int OFF_W = 8;
    localparam int OPC_W = 5;
    localparam int CLS_W = 3;
    localparam int GRP_W = 3;

    localparam logic [GRP_W-1:0] GRP_JMP = 3'b000;
    localparam logic [GRP_W-1:0] GRP_EXT = 3'b001;
    localparam logic [GRP_W-1:0] GRP_ADD = 3'b010;
    localparam logic [GRP_W-1:0] GRP_SUB = 3'b011;
    localparam logic [GRP_W-1:0] GRP_AND = 3'b100;
    localparam logic [GRP_W-1:0] GRP_OR = 3'b101;
    localparam logic [GRP_W-1:0] GRP_FA = 3'b110;
    localparam logic [GRP_W-1:0] GRP_FS = 3'b111;

    localparam logic [1:0] SUB_JLR = 2'b00;
    localparam logic [1:0] SUB_JTR = 2'b01;
    localparam logic [1:0] SUB_CRF = 2'b10;
    localparam logic [1:0] SUB_MEM = 2'b11;

    localparam logic [CRF_W-1:0] CRF_INT = 3'd0;
    localparam logic [CRF_W-1:0] CRF_FLT = 3'd1;

    typedef enum logic [CLS_W-1:0] {
        CL_NONE = 3'd0,
        CL_JMP = 3'd1,
        CL_MEM = 3'd2,
        CL_INT = 3'd3,
        CL_LOG = 3'd4,
        CL_FP = 3'd5,
        CL_CRF = 3'd6
    } cls_e;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP = 5'd0,
        OP_JMP = 5'd1,
        OP_JLR = 5'd2,
        OP_JTR = 5'd3,
        OP_LD = 5'd4,
        OP_ST = 5'd5,
        OP_ADD = 5'd6,
        OP_MUL = 5'd7,
        OP_SUB = 5'd8,
        OP_CMP = 5'd9,
        OP_AND = 5'd10,
        OP_NAND = 5'd11,
        OP_OR = 5'd12,
        OP_NOR = 5'd13,
        OP_FADD = 5'd14,
        OP_FABS = 5'd15,
        OP_FMUL = 5'd16,
        OP_FSUB = 5'd17,
        OP_FCMP = 5'd18,
        OP_CRF = 5'd19
    } op_e;

    typedef struct packed {
        cls_e cls;
        op_e opc;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rd;
        logic a_zero;
        logic wr;
        logic cmp;
        logic [CRF_W-1:0] crf;
        logic lnk;
        logic cond_en;
        logic cond_inv;
        logic [1:0] cond_sel;
        logic [OFF_W-1:0] offs;
        logic ill;
    } uop_t;

    localparam uop_t UOP_NULL = '0;

    // signed halfword count -> signed byte offset
    function automatic logic [OFF_W-1:0] half_to_bytes(input logic [FLD_W-1:0] f);
        return {{(OFF_W-FLD_W-1){f[FLD_W-1]}}, f, 1'b0};
    endfunction

    function automatic logic [REG_W-1:0] short_reg(input logic [SREG_W-1:0] r);
        return {{(REG_W-SREG_W){1'b0}}, r};
    endfunction

endpackage

// File: rtl/pd10_jmp_dec.sv
module pd10_jmp_dec
    import pd10_pkg::*;
(
    input  logic [10:1] f,
    output uop_t        uop
);
    logic is_rel;
    logic bad_cond;

    assign is_rel = (f[10:8] == GRP_JMP);
    assign bad_cond = !f[3] && f[2];

    always_comb begin
        uop = UOP_NULL;
        uop.cls = CL_JMP;
        uop.lnk = f[1];
        if (is_rel) begin
            uop.opc = OP_JMP;
            uop.offs = half_to_bytes(f[7:2]);
        end else if (bad_cond) begin
            uop = UOP_NULL;
            uop.ill = 1'b1;
        end else begin
            uop.opc = f[6] ? OP_JTR : OP_JLR;
            uop.cond_sel = f[5:4];
            uop.cond_en = f[3];
            uop.cond_inv = f[2];
        end
    end

    // R9
    always_comb begin
        inv_only_chk: assert (!(uop.cond_inv && !uop.cond_en));
    end
endmodule

// File: rtl/pd10_mem_dec.sv
module pd10_mem_dec
    import pd10_pkg::*;
(
    input  logic [5:1] f,
    output uop_t       uop
);
    logic [REG_W-1:0] addr_r;
    logic [REG_W-1:0] pair_r;

    assign addr_r = short_reg(f[5:4]);
    assign pair_r = short_reg(f[3:2]);

    always_comb begin
        uop = UOP_NULL;
        uop.cls = CL_MEM;
        uop.ra = addr_r;
        uop.rb = pair_r;
        if (f[1]) begin
            uop.opc = OP_ST;
        end else begin
            uop.opc = OP_LD;
            uop.rd = pair_r;
            uop.wr = 1'b1;
        end
    end

    // R10
    always_comb begin
        short_regs_chk: assert (uop.ra < 3'd4 && uop.rb < 3'd4);
    end
endmodule

// File: rtl/pd10_alu_dec.sv
module pd10_alu_dec
    import pd10_pkg::*;
(
    input  logic [10:1] f,
    output uop_t        uop
);
    logic [GRP_W-1:0] grp;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic alt;
    logic ra_nil;

    assign grp = f[10:8];
    assign rb = f[7:5];
    assign ra = f[4:2];
    assign alt = f[1];
    assign ra_nil = (ra == '0);

    always_comb begin
        uop = UOP_NULL;
        uop.ra = ra;
        uop.rb = rb;
        uop.rd = ra;
        uop.wr = 1'b1;
        unique case (grp)
            GRP_ADD: begin
                uop.cls = CL_INT;
                uop.opc = alt ? OP_MUL : OP_ADD;
            end
            GRP_SUB: begin
                uop.cls = CL_INT;
                uop.opc = alt ? OP_CMP : OP_SUB;
                uop.a_zero = ra_nil;
                if (alt) begin
                    uop.wr = 1'b0;
                    uop.rd = '0;
                    uop.cmp = 1'b1;
                    uop.crf = CRF_INT;
                end
            end
            GRP_AND: begin
                uop.cls = CL_LOG;
                uop.opc = alt ? OP_NAND : OP_AND;
            end
            GRP_OR: begin
                uop.cls = CL_LOG;
                uop.opc = alt ? OP_NOR : OP_OR;
                uop.a_zero = alt && ra_nil;
            end
            GRP_FA: begin
                uop.cls = CL_FP;
                if (alt) uop.opc = OP_FMUL;
                else uop.opc = ra_nil ? OP_FABS : OP_FADD;
            end
            GRP_FS: begin
                uop.cls = CL_FP;
                uop.opc = alt ? OP_FCMP : OP_FSUB;
                uop.a_zero = ra_nil;
                if (alt) begin
                    uop.wr = 1'b0;
                    uop.rd = '0;
                    uop.cmp = 1'b1;
                    uop.crf = CRF_FLT;
                end
            end
            default: uop = UOP_NULL;
        endcase
    end

    // R4
    always_comb begin
        zero_field_chk: assert (!uop.a_zero || uop.ra == '0);
    end
endmodule

// File: rtl/pd10_decode.sv
module pd10_decode
    import pd10_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [PCL_W-1:0] in_pcl,
    output logic             out_vld,
    output logic [CLS_W-1:0] out_cls,
    output logic [OPC_W-1:0] out_opc,
    output logic [REG_W-1:0] out_ra,
    output logic [REG_W-1:0] out_rb,
    output logic [REG_W-1:0] out_rd,
    output logic             out_a_zero,
    output logic             out_wr,
    output logic             out_cmp,
    output logic [CRF_W-1:0] out_crf,
    output logic             out_lnk,
    output logic             out_cond_en,
    output logic             out_cond_inv,
    output logic [1:0]       out_cond_sel,
    output logic [OFF_W-1:0] out_offs,
    output logic             out_ill,
    output logic             out_stay
);
    logic [GRP_W-1:0] grp;
    logic [1:0] sub;
    logic unused_major;
    uop_t jmp_u, mem_u, alu_u, crf_u, nxt, q;
    logic q_vld, q_stay;

    assign grp = in_pcl[10:8];
    assign sub = in_pcl[7:6];
    assign unused_major = ^in_pcl[15:11];

    pd10_jmp_dec u_jmp (.f(in_pcl[10:1]), .uop(jmp_u));
    pd10_mem_dec u_mem (.f(in_pcl[5:1]), .uop(mem_u));
    pd10_alu_dec u_alu (.f(in_pcl[10:1]), .uop(alu_u));

    always_comb begin
        crf_u = UOP_NULL;
        crf_u.cls = CL_CRF;
        crf_u.opc = OP_CRF;
    end

    always_comb begin
        if (grp == GRP_JMP) begin
            nxt = jmp_u;
        end else if (grp == GRP_EXT) begin
            unique case (sub)
                SUB_JLR, SUB_JTR: nxt = jmp_u;
                SUB_MEM: nxt = mem_u;
                default: nxt = crf_u;
            endcase
        end else begin
            nxt = alu_u;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= UOP_NULL;
            q_vld <= 1'b0;
            q_stay <= 1'b0;
        end else begin
            q_vld <= in_vld;
            if (in_vld) begin
                q <= nxt;
                q_stay <= in_pcl[0];
            end
        end
    end

    assign out_vld = q_vld;
    assign out_cls = q.cls;
    assign out_opc = q.opc;
    assign out_ra = q.ra;
    assign out_rb = q.rb;
    assign out_rd = q.rd;
    assign out_a_zero = q.a_zero;
    assign out_wr = q.wr;
    assign out_cmp = q.cmp;
    assign out_crf = q.crf;
    assign out_lnk = q.lnk;
    assign out_cond_en = q.cond_en;
    assign out_cond_inv = q.cond_inv;
    assign out_cond_sel = q.cond_sel;
    assign out_offs = q.offs;
    assign out_ill = q.ill;
    assign out_stay = q_stay;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_opc) && $stable(out_rd) && $stable(out_offs)));
    // R9
    ill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_ill |-> !(out_wr || out_cmp || out_lnk || out_cond_en || out_a_zero));
    // R6
    cmp_target_chk: assert property (@(posedge clk) disable iff (rst)
        out_cmp |-> (!out_wr && out_crf <= CRF_FLT));
    // R8
    cond_pair_chk: assert property (@(posedge clk) disable iff (rst)
        out_cond_inv |-> out_cond_en);
endmodule

// File: tb/pd10_decode_test.sv
module pd10_decode_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic [15:0] in_pcl = '0;
    logic out_vld, out_a_zero, out_wr, out_cmp, out_lnk, out_cond_en, out_cond_inv, out_ill, out_stay;
    logic [2:0] out_cls, out_ra, out_rb, out_rd, out_crf;
    logic [4:0] out_opc;
    logic [1:0] out_cond_sel;
    logic [7:0] out_offs;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pd10_decode uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_pcl(in_pcl),
        .out_vld(out_vld), .out_cls(out_cls), .out_opc(out_opc),
        .out_ra(out_ra), .out_rb(out_rb), .out_rd(out_rd),
        .out_a_zero(out_a_zero), .out_wr(out_wr), .out_cmp(out_cmp),
        .out_crf(out_crf), .out_lnk(out_lnk), .out_cond_en(out_cond_en),
        .out_cond_inv(out_cond_inv), .out_cond_sel(out_cond_sel),
        .out_offs(out_offs), .out_ill(out_ill), .out_stay(out_stay)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one valid parcel, return at the negedge after the capturing edge
    task automatic send(input logic [15:0] p);
        @(negedge clk);
        in_vld = 1'b1;
        in_pcl = p;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    function automatic logic [15:0] alu_p(input logic [2:0] g, input logic [2:0] rb,
                                          input logic [2:0] ra, input logic alt);
        return {5'b10011, g, rb, ra, alt, 1'b1};
    endfunction

    task automatic t_reset;
        chk("R1", "vld", out_vld, 0);
        chk("R1", "ill", out_ill, 0);
        chk("R1", "wr", out_wr, 0);
        chk("R1", "cmp", out_cmp, 0);
        chk("R1", "lnk", out_lnk, 0);
        chk("R1", "cond_en", out_cond_en, 0);
        chk("R1", "stay", out_stay, 0);
    endtask

    task automatic t_int_logic;
        send(alu_p(3'b010, 3'd5, 3'd3, 1'b0));
        chk("R3", "add vld", out_vld, 1);
        chk("R3", "add cls", out_cls, 3);
        chk("R3", "add opc", out_opc, 6);
        chk("R3", "add ra", out_ra, 3);
        chk("R3", "add rb", out_rb, 5);
        chk("R3", "add rd", out_rd, 3);
        chk("R3", "add wr", out_wr, 1);
        send(alu_p(3'b010, 3'd1, 3'd6, 1'b1));
        chk("R3", "mul opc", out_opc, 7);
        send(alu_p(3'b100, 3'd2, 3'd0, 1'b0));
        chk("R3", "and cls", out_cls, 4);
        chk("R3", "and opc", out_opc, 10);
        chk("R4", "and no zero", out_a_zero, 0);
        send(alu_p(3'b100, 3'd2, 3'd7, 1'b1));
        chk("R3", "nand opc", out_opc, 11);
        send(alu_p(3'b101, 3'd4, 3'd0, 1'b0));
        chk("R3", "or opc", out_opc, 12);
        chk("R4", "or no zero", out_a_zero, 0);
    endtask

    task automatic t_zero_forms;
        send(alu_p(3'b011, 3'd2, 3'd0, 1'b0));
        chk("R4", "neg opc", out_opc, 8);
        chk("R4", "neg zero", out_a_zero, 1);
        chk("R4", "neg wr", out_wr, 1);
        send(alu_p(3'b011, 3'd2, 3'd4, 1'b0));
        chk("R4", "sub zero", out_a_zero, 0);
        send(alu_p(3'b101, 3'd6, 3'd0, 1'b1));
        chk("R4", "not opc", out_opc, 13);
        chk("R4", "not zero", out_a_zero, 1);
        send(alu_p(3'b101, 3'd6, 3'd1, 1'b1));
        chk("R4", "nor zero", out_a_zero, 0);
        send(alu_p(3'b111, 3'd3, 3'd0, 1'b0));
        chk("R4", "fneg opc", out_opc, 17);
        chk("R4", "fneg zero", out_a_zero, 1);
    endtask

    task automatic t_compare;
        send(alu_p(3'b011, 3'd1, 3'd2, 1'b1));
        chk("R6", "cmp opc", out_opc, 9);
        chk("R6", "cmp en", out_cmp, 1);
        chk("R6", "cmp crf", out_crf, 0);
        chk("R6", "cmp wr", out_wr, 0);
        chk("R4", "cmp zero", out_a_zero, 0);
        send(alu_p(3'b111, 3'd5, 3'd0, 1'b1));
        chk("R6", "fcmp opc", out_opc, 18);
        chk("R6", "fcmp crf", out_crf, 1);
        chk("R6", "fcmp wr", out_wr, 0);
        chk("R4", "fcmp zero", out_a_zero, 1);
    endtask

    task automatic t_float;
        send(alu_p(3'b110, 3'd2, 3'd1, 1'b0));
        chk("R5", "fadd cls", out_cls, 5);
        chk("R5", "fadd opc", out_opc, 14);
        send(alu_p(3'b110, 3'd2, 3'd0, 1'b0));
        chk("R5", "fabs opc", out_opc, 15);
        send(alu_p(3'b110, 3'd2, 3'd0, 1'b1));
        chk("R5", "fmul opc", out_opc, 16);
    endtask

    task automatic t_rel_jump;
        send({5'b00000, 3'b000, 6'b111111, 1'b1, 1'b0});
        chk("R7", "jmp cls", out_cls, 1);
        chk("R7", "jmp opc", out_opc, 1);
        chk("R7", "offs -1", out_offs, 8'hFE);
        chk("R7", "lnk", out_lnk, 1);
        send({5'b00000, 3'b000, 6'b011111, 1'b0, 1'b0});
        chk("R7", "offs max", out_offs, 8'h3E);
        chk("R7", "no lnk", out_lnk, 0);
        send({5'b00000, 3'b000, 6'b100000, 1'b0, 1'b0});
        chk("R7", "offs min", out_offs, 8'hC0);
    endtask

    task automatic t_cond_jump;
        send({5'b00000, 3'b001, 2'b00, 2'd2, 2'b11, 1'b0, 1'b0});
        chk("R8", "jlr opc", out_opc, 2);
        chk("R8", "sel", out_cond_sel, 2);
        chk("R8", "en", out_cond_en, 1);
        chk("R8", "inv", out_cond_inv, 1);
        chk("R8", "lnk", out_lnk, 0);
        send({5'b00000, 3'b001, 2'b01, 2'd1, 2'b10, 1'b1, 1'b0});
        chk("R8", "jtr opc", out_opc, 3);
        chk("R8", "sel b", out_cond_sel, 1);
        chk("R8", "inv b", out_cond_inv, 0);
        chk("R8", "lnk b", out_lnk, 1);
        send({5'b00000, 3'b001, 2'b00, 2'd3, 2'b00, 1'b0, 1'b0});
        chk("R8", "uncond en", out_cond_en, 0);
        chk("R9", "uncond legal", out_ill, 0);
    endtask

    task automatic t_illegal;
        send({5'b00000, 3'b001, 2'b01, 2'd1, 2'b01, 1'b1, 1'b0});
        chk("R9", "ill", out_ill, 1);
        chk("R9", "lnk", out_lnk, 0);
        chk("R9", "en", out_cond_en, 0);
        chk("R9", "inv", out_cond_inv, 0);
        chk("R9", "wr", out_wr, 0);
    endtask

    task automatic t_mem;
        send({5'b00000, 3'b001, 2'b11, 2'd2, 2'd3, 1'b0, 1'b0});
        chk("R10", "ld cls", out_cls, 2);
        chk("R10", "ld opc", out_opc, 4);
        chk("R10", "ld ra", out_ra, 2);
        chk("R10", "ld rb", out_rb, 3);
        chk("R10", "ld rd", out_rd, 3);
        chk("R10", "ld wr", out_wr, 1);
        send({5'b00000, 3'b001, 2'b11, 2'd1, 2'd2, 1'b1, 1'b0});
        chk("R11", "st opc", out_opc, 5);
        chk("R11", "st ra", out_ra, 1);
        chk("R11", "st rb", out_rb, 2);
        chk("R11", "st wr", out_wr, 0);
        chk("R11", "st offs", out_offs, 0);
    endtask

    task automatic t_crf;
        send({5'b00000, 3'b001, 2'b10, 4'b0110, 1'b1, 1'b0});
        chk("R12", "cls", out_cls, 6);
        chk("R12", "opc", out_opc, 19);
        chk("R12", "wr", out_wr, 0);
        chk("R12", "lnk", out_lnk, 0);
        chk("R12", "ill", out_ill, 0);
    endtask

    task automatic t_stay_major;
        send({5'b11111, 3'b010, 3'd2, 3'd1, 1'b0, 1'b1});
        chk("R13", "stay 1", out_stay, 1);
        chk("R13", "major ignored opc", out_opc, 6);
        chk("R13", "major ignored ra", out_ra, 1);
        send({5'b00000, 3'b010, 3'd2, 3'd1, 1'b0, 1'b0});
        chk("R13", "stay 0", out_stay, 0);
        chk("R13", "same opc", out_opc, 6);
    endtask

    task automatic t_hold;
        send(alu_p(3'b110, 3'd4, 3'd3, 1'b1));
        @(negedge clk);
        in_pcl = alu_p(3'b011, 3'd0, 3'd0, 1'b0);
        @(negedge clk);
        chk("R2", "idle vld", out_vld, 0);
        chk("R2", "held opc", out_opc, 16);
        chk("R2", "held rd", out_rd, 3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_int_logic();
        t_zero_forms();
        t_compare();
        t_float();
        t_rel_jump();
        t_cond_jump();
        t_illegal();
        t_mem();
        t_crf();
        t_stay_major();
        t_hold();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule